// File: doc/BRIEF.md
# Trace Buffer Write Controller

This block decides where each execution-trace packet lands in an on-chip SRAM region used as a ring. It keeps a position register made of a packet pointer and a wrap flag, a control register and a watermark register. Each accepted packet moves the pointer forward by 8 bytes. The movement stays inside a power-of-two window set by a mask field, and the pointer bits above the window never change. The window therefore lets the ring sit anywhere in memory, aligned to its own size.

Tracing is switched on and off by software, by two trigger inputs gated with their own enables, and by a watermark compare. The watermark compare can also raise a debug halt request. A small register port gives software access to the three registers and checks the caller's privilege. A gate on the SRAM access path hides the trace memory from user-mode accesses when software asks for that. A parameter removes all privilege handling.

Top module: `tbuf_wctl`

## Requirements
- R1: After reset: tracing is disabled, the pointer is 0, the wrap flag is 0, the halt bit is 0, the SRAM-privilege bit is 0, and the register-write-privilege bit is 1 (0 when privilege support is absent). Register map, read combinationally on `reg_rdata`:
  - Address 0 (position): pointer byte address in bits [AWIDTH-1:3], wrap flag in bit 0.
  - Address 1 (control): enable [0], start-enable [1], stop-enable [2], halt [3], register-write-privilege [4], SRAM-privilege [5], mask [12:8].
  - Address 2 (watermark): watermark byte address in bits [AWIDTH-1:3], watermark-stop in bit 0.
  - Address 3: reads as zero.
- R2: A `pkt_wr` pulse while tracing is enabled is accepted. During that cycle `trace_wr_en` is 1 and `trace_wr_addr` shows the current pointer, and after the clock edge the pointer has grown by 8 bytes. While tracing is disabled, `trace_wr_en` stays 0 and the pointer does not move.
- R3: With effective mask m, the ring is 2^(m+4) bytes. An advance from the last 8-byte slot of the ring does three things: it clears pointer byte bits [m+3:3], it leaves the higher pointer bits unchanged, and it sets the wrap flag. The wrap flag then stays 1 until software writes the position register.
- R4: A mask value greater than AWIDTH-4 acts exactly like AWIDTH-4.
- R5: When start-enable is 1 and `trace_start` is high at a clock edge, tracing becomes enabled. `trace_start` has no effect while start-enable is 0.
- R6: When stop-enable is 1 and `trace_stop` is high at a clock edge, tracing becomes disabled. A stop wins over a simultaneous start. A packet accepted in the same cycle as the stop still advances the pointer.
- R7: While the register-write-privilege bit is 1, register writes with `reg_priv` low are ignored. While that bit is 0, writes at either privilege level take effect. Reads are always served.
- R8: While the SRAM-privilege bit is 1, an SRAM access with `ram_priv` low has its write enable and enable suppressed, and it returns zero on `ram_rdata`. Privileged accesses always pass through.
- R9: `halt_req` is high exactly when the halt bit is 1 and `dbg_en` is high. Once set, the halt bit is cleared only by a software write.
- R10: While tracing is enabled and the pointer equals the watermark, the halt bit is set at the next edge. If watermark-stop is 1, tracing is disabled at that same edge.
- R11: With privilege support absent (`PRIV_EN` = 0), both privilege bits read 0, writes to them are dropped, and `reg_priv` and `ram_priv` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register port select |
| reg_wr | input | 1 | Register write strobe (with reg_sel) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_priv | input | 1 | Register access is privileged |
| reg_rdata | output | 32 | Register read data (combinational) |
| pkt_wr | input | 1 | Trace source writes one packet this cycle |
| trace_start | input | 1 | Start trigger |
| trace_stop | input | 1 | Stop trigger |
| trace_wr_en | output | 1 | Packet write enable toward SRAM |
| trace_wr_addr | output | AWIDTH | Packet byte address toward SRAM |
| dbg_en | input | 1 | Debug permitted |
| halt_req | output | 1 | Debug halt request |
| ram_req | input | 1 | Bus access to trace SRAM |
| ram_wr | input | 1 | Bus access is a write |
| ram_priv | input | 1 | Bus access is privileged |
| sram_rdata | input | 32 | Read data from SRAM |
| sram_en | output | 1 | Gated SRAM enable |
| sram_we | output | 1 | Gated SRAM write enable |
| ram_rdata | output | 32 | Gated read data to bus |

## Verification
The bench walks pointer advances across several mask sizes. It starts each one at slots just below and just at the ring edge, so a design that carries into the fixed upper bits, or that forgets to set the wrap flag, shows a wrong position readback. Masks above the limit are tried with a pointer whose low eight index bits are all ones, which exposes a design that truncates the mask instead of clamping it. A stop that arrives together with a packet checks that the packet is not lost. A simultaneous start and stop checks that the stop wins. User writes under write-privilege, user SRAM accesses under SRAM-privilege, and a build without privilege support check that the blocked paths leave the control state and SRAM untouched.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

    typedef enum logic [1:0] {
        RA_POS   = 2'd0,
        RA_CTRL  = 2'd1,
        RA_WMARK = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    localparam int MASK_W     = 5;
    localparam int CB_EN      = 0;
    localparam int CB_START   = 1;
    localparam int CB_STOP    = 2;
    localparam int CB_HALT    = 3;
    localparam int CB_WPRIV   = 4;
    localparam int CB_RPRIV   = 5;
    localparam int CB_MASK_LO = 8;
    localparam int PKT_SHIFT  = 3;

    typedef struct packed {
        logic              en;
        logic              start_en;
        logic              stop_en;
        logic              halt;
        logic              wpriv;
        logic              rpriv;
        logic [MASK_W-1:0] mask;
    } ctrl_t;

endpackage

// File: rtl/tbuf_ptr_step.sv
module tbuf_ptr_step #(
    parameter int IW = 9,
    parameter int MW = 5
) (
    input  logic [IW-1:0] idx,
    input  logic [MW-1:0] mask,
    output logic [IW-1:0] idx_next,
    output logic          wrap,
    output logic [IW-1:0] win
);
    localparam int LIMIT = IW - 1;

    logic [MW-1:0] eff;

    always_comb begin
        if (int'(mask) > LIMIT) eff = MW'(LIMIT);
        else                    eff = mask;
    end

    for (genvar i = 0; i < IW; i++) begin : g_win
        assign win[i] = (int'(eff) >= i);
    end

    always_comb begin
        wrap = &(idx | ~win);
        if (wrap) idx_next = idx & ~win;
        else      idx_next = (idx & ~win) | ((idx + IW'(1)) & win);
    end
endmodule

// File: rtl/tbuf_ram_gate.sv
module tbuf_ram_gate #(
    parameter bit PRIV_EN = 1'b1,
    parameter int DW      = 32
) (
    input  logic          guard,
    input  logic          ram_req,
    input  logic          ram_wr,
    input  logic          ram_priv,
    input  logic [DW-1:0] sram_rdata,
    output logic          sram_en,
    output logic          sram_we,
    output logic [DW-1:0] ram_rdata
);
    logic blocked;

    always_comb begin
        blocked   = PRIV_EN && guard && !ram_priv;
        sram_en   = ram_req && !blocked;
        sram_we   = sram_en && ram_wr;
        ram_rdata = blocked ? '0 : sram_rdata;
    end
endmodule

// File: rtl/tbuf_regs.sv
module tbuf_regs
    import tbuf_pkg::*;
#(
    parameter int AWIDTH  = 12,
    parameter bit PRIV_EN = 1'b1,
    parameter int DW      = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_sel,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_addr,
    input  logic [DW-1:0]           reg_wdata,
    input  logic                    reg_priv,
    output logic [DW-1:0]           reg_rdata,
    input  logic                    pkt_wr,
    input  logic                    trace_start,
    input  logic                    trace_stop,
    output logic [AWIDTH-4:0]       ptr_idx,
    output logic                    accept,
    output ctrl_t                   ctrl
);
    localparam int IW = AWIDTH - PKT_SHIFT;

    typedef struct packed {
        logic [IW-1:0] ptr;
        logic          wrap;
        logic [IW-1:0] wm;
        logic          wm_stop;
        ctrl_t         ctrl;
    } state_t;

    function automatic state_t rst_state();
        state_t s = '0;
        s.ctrl.wpriv = PRIV_EN;
        return s;
    endfunction

    state_t s_d, s_q;

    logic          wr_ok;
    logic          pos_wr;
    logic          ctrl_wr;
    logic          wm_hit;
    logic [IW-1:0] step_next;
    logic          step_wrap;
    logic [IW-1:0] step_win;
    logic          unused_wdata;

    assign unused_wdata = ^reg_wdata;

    tbuf_ptr_step #(.IW(IW), .MW(MASK_W)) u_step (
        .idx      (s_q.ptr),
        .mask     (s_q.ctrl.mask),
        .idx_next (step_next),
        .wrap     (step_wrap),
        .win      (step_win)
    );

    always_comb begin
        s_d     = s_q;
        wr_ok   = reg_sel && reg_wr && (!PRIV_EN || !s_q.ctrl.wpriv || reg_priv);
        pos_wr  = wr_ok && (reg_addr_e'(reg_addr) == RA_POS);
        ctrl_wr = wr_ok && (reg_addr_e'(reg_addr) == RA_CTRL);
        accept  = pkt_wr && s_q.ctrl.en;
        wm_hit  = s_q.ctrl.en && (s_q.ptr == s_q.wm);

        if (wr_ok) begin
            case (reg_addr_e'(reg_addr))
                RA_POS: begin
                    s_d.ptr  = reg_wdata[AWIDTH-1:PKT_SHIFT];
                    s_d.wrap = reg_wdata[0];
                end
                RA_CTRL: begin
                    s_d.ctrl.en       = reg_wdata[CB_EN];
                    s_d.ctrl.start_en = reg_wdata[CB_START];
                    s_d.ctrl.stop_en  = reg_wdata[CB_STOP];
                    s_d.ctrl.halt     = reg_wdata[CB_HALT];
                    s_d.ctrl.wpriv    = PRIV_EN && reg_wdata[CB_WPRIV];
                    s_d.ctrl.rpriv    = PRIV_EN && reg_wdata[CB_RPRIV];
                    s_d.ctrl.mask     = reg_wdata[CB_MASK_LO +: MASK_W];
                end
                RA_WMARK: begin
                    s_d.wm      = reg_wdata[AWIDTH-1:PKT_SHIFT];
                    s_d.wm_stop = reg_wdata[0];
                end
                default: ;
            endcase
        end

        if (accept && !pos_wr) begin
            s_d.ptr = step_next;
            if (step_wrap) s_d.wrap = 1'b1;
        end

        if (s_q.ctrl.start_en && trace_start) s_d.ctrl.en = 1'b1;
        if (s_q.ctrl.stop_en && trace_stop)   s_d.ctrl.en = 1'b0;

        if (wm_hit) begin
            s_d.ctrl.halt = 1'b1;
            if (s_q.wm_stop) s_d.ctrl.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= rst_state();
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_POS: begin
                reg_rdata[AWIDTH-1:PKT_SHIFT] = s_q.ptr;
                reg_rdata[0]                  = s_q.wrap;
            end
            RA_CTRL: begin
                reg_rdata[CB_EN]                = s_q.ctrl.en;
                reg_rdata[CB_START]             = s_q.ctrl.start_en;
                reg_rdata[CB_STOP]              = s_q.ctrl.stop_en;
                reg_rdata[CB_HALT]              = s_q.ctrl.halt;
                reg_rdata[CB_WPRIV]             = s_q.ctrl.wpriv;
                reg_rdata[CB_RPRIV]             = s_q.ctrl.rpriv;
                reg_rdata[CB_MASK_LO +: MASK_W] = s_q.ctrl.mask;
            end
            RA_WMARK: begin
                reg_rdata[AWIDTH-1:PKT_SHIFT] = s_q.wm;
                reg_rdata[0]                  = s_q.wm_stop;
            end
            default: ;
        endcase
    end

    assign ptr_idx = s_q.ptr;
    assign ctrl    = s_q.ctrl;

    // R2
    advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pos_wr && !step_wrap) |=> (s_q.ptr == $past(s_q.ptr) + IW'(1)));

    // R3
    upper_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pos_wr) |=> ((s_q.ptr & ~$past(step_win)) == ($past(s_q.ptr) & ~$past(step_win))));

    // R3
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wrap && !pos_wr) |=> s_q.wrap);

    // R6
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.stop_en && trace_stop) |=> !s_q.ctrl.en);

    // R7
    user_wr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && !reg_priv && s_q.ctrl.wpriv) |=> $stable(s_q.ctrl.mask));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.halt && !ctrl_wr) |=> s_q.ctrl.halt);

    // R10
    wm_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wm_hit |=> s_q.ctrl.halt);
endmodule

// File: rtl/tbuf_wctl.sv
module tbuf_wctl
    import tbuf_pkg::*;
#(
    parameter int AWIDTH  = 12,
    parameter bit PRIV_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_priv,
    output logic [31:0]       reg_rdata,
    input  logic              pkt_wr,
    input  logic              trace_start,
    input  logic              trace_stop,
    output logic              trace_wr_en,
    output logic [AWIDTH-1:0] trace_wr_addr,
    input  logic              dbg_en,
    output logic              halt_req,
    input  logic              ram_req,
    input  logic              ram_wr,
    input  logic              ram_priv,
    input  logic [31:0]       sram_rdata,
    output logic              sram_en,
    output logic              sram_we,
    output logic [31:0]       ram_rdata
);
    localparam int IW = AWIDTH - PKT_SHIFT;
    localparam int DW = 32;

    logic [IW-1:0] ptr_idx;
    logic          accept;
    ctrl_t         ctrl;

    tbuf_regs #(.AWIDTH(AWIDTH), .PRIV_EN(PRIV_EN), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_sel     (reg_sel),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_priv    (reg_priv),
        .reg_rdata   (reg_rdata),
        .pkt_wr      (pkt_wr),
        .trace_start (trace_start),
        .trace_stop  (trace_stop),
        .ptr_idx     (ptr_idx),
        .accept      (accept),
        .ctrl        (ctrl)
    );

    tbuf_ram_gate #(.PRIV_EN(PRIV_EN), .DW(DW)) u_gate (
        .guard      (ctrl.rpriv),
        .ram_req    (ram_req),
        .ram_wr     (ram_wr),
        .ram_priv   (ram_priv),
        .sram_rdata (sram_rdata),
        .sram_en    (sram_en),
        .sram_we    (sram_we),
        .ram_rdata  (ram_rdata)
    );

    assign trace_wr_en   = accept;
    assign trace_wr_addr = {ptr_idx, {PKT_SHIFT{1'b0}}};
    assign halt_req      = ctrl.halt && dbg_en;

    // R8
    ram_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PRIV_EN && ctrl.rpriv && ram_req && !ram_priv) |-> (!sram_we && !sram_en && ram_rdata == '0));
endmodule

// File: tb/tbuf_wctl_tb.sv
module tbuf_wctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    // {mask[29:25], start[24:13], expected[12:1], wrap[0]}
    localparam logic [29:0] VEC [9] = '{
        {5'd0,  12'h000, 12'h008, 1'b0},
        {5'd0,  12'h008, 12'h000, 1'b1},
        {5'd0,  12'h7F8, 12'h7F0, 1'b1},
        {5'd2,  12'h130, 12'h138, 1'b0},
        {5'd2,  12'h138, 12'h100, 1'b1},
        {5'd8,  12'h7F8, 12'h800, 1'b0},
        {5'd7,  12'hFF8, 12'h800, 1'b1},
        {5'd9,  12'hFF8, 12'h000, 1'b1},
        {5'd31, 12'hFF8, 12'h000, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_sel = 0, reg_wr = 0, reg_priv = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic pkt_wr = 0, trace_start = 0, trace_stop = 0, dbg_en = 0;
    logic ram_req = 0, ram_wr = 0, ram_priv = 0;
    logic [31:0] sram_rdata = 32'hDEADBEEF;

    logic [31:0] reg_rdata, ram_rdata, np_rdata, np_ram_rdata;
    logic trace_wr_en, halt_req, sram_en, sram_we;
    logic np_wr_en, np_halt, np_sram_en, np_sram_we;
    logic [AW-1:0] trace_wr_addr, np_wr_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv, rv_np;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbuf_wctl #(.AWIDTH(AW), .PRIV_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_priv(reg_priv),
        .reg_rdata(reg_rdata), .pkt_wr(pkt_wr), .trace_start(trace_start),
        .trace_stop(trace_stop), .trace_wr_en(trace_wr_en),
        .trace_wr_addr(trace_wr_addr), .dbg_en(dbg_en), .halt_req(halt_req),
        .ram_req(ram_req), .ram_wr(ram_wr), .ram_priv(ram_priv),
        .sram_rdata(sram_rdata), .sram_en(sram_en), .sram_we(sram_we),
        .ram_rdata(ram_rdata)
    );

    tbuf_wctl #(.AWIDTH(AW), .PRIV_EN(1'b0)) u_np (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_priv(reg_priv),
        .reg_rdata(np_rdata), .pkt_wr(pkt_wr), .trace_start(trace_start),
        .trace_stop(trace_stop), .trace_wr_en(np_wr_en),
        .trace_wr_addr(np_wr_addr), .dbg_en(dbg_en), .halt_req(np_halt),
        .ram_req(ram_req), .ram_wr(ram_wr), .ram_priv(ram_priv),
        .sram_rdata(sram_rdata), .sram_en(np_sram_en), .sram_we(np_sram_we),
        .ram_rdata(np_ram_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d; reg_priv = p;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; reg_priv = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        reg_addr = a;
        #1;
        rv = reg_rdata;
        rv_np = np_rdata;
    endtask

    task automatic pulse_pkt();
        @(negedge clk);
        pkt_wr = 1;
        @(negedge clk);
        pkt_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0); chk("R1 position", rv, 32'h0);
        rd(2'd1); chk("R1 control", rv, 32'h10);
        chk("R11 control no-priv", rv_np, 32'h0);
        rd(2'd2); chk("R1 watermark", rv, 32'h0);
        rd(2'd3); chk("R1 unused address", rv, 32'h0);
        chk("R1 halt_req", {31'b0, halt_req}, 32'h0);

        // R7 / R11 write privilege
        wr(2'd1, 32'h330, 1'b0);
        rd(2'd1); chk("R7 user write ignored", rv, 32'h10);
        chk("R11 user write lands, priv bits dropped", rv_np, 32'h300);
        wr(2'd1, 32'h200, 1'b1);
        rd(2'd1); chk("R7 privileged write", rv, 32'h200);
        wr(2'd1, 32'h100, 1'b0);
        rd(2'd1); chk("R7 user write when open", rv, 32'h100);

        // R8 / R11 SRAM privilege
        wr(2'd1, 32'h20, 1'b1);
        rd(2'd1); chk("R11 rpriv reads zero", rv_np, 32'h0);
        @(negedge clk);
        ram_req = 1; ram_wr = 1; ram_priv = 0; #1;
        chk("R8 user write blocked", {30'b0, sram_en, sram_we}, 32'h0);
        chk("R8 user read zero", ram_rdata, 32'h0);
        chk("R11 user access passes", {30'b0, np_sram_en, np_sram_we}, 32'h3);
        chk("R11 user read passes", np_ram_rdata, 32'hDEADBEEF);
        ram_priv = 1; #1;
        chk("R8 privileged write", {30'b0, sram_en, sram_we}, 32'h3);
        chk("R8 privileged read", ram_rdata, 32'hDEADBEEF);
        ram_req = 0; ram_wr = 0; ram_priv = 0;
        wr(2'd1, 32'h0, 1'b1);
        @(negedge clk);
        ram_req = 1; #1;
        chk("R8 user read open", ram_rdata, 32'hDEADBEEF);
        ram_req = 0;

        // R9 halt request
        wr(2'd1, 32'h8, 1'b1);
        dbg_en = 0; #1;
        chk("R9 halt without dbg_en", {31'b0, halt_req}, 32'h0);
        dbg_en = 1; #1;
        chk("R9 halt with dbg_en", {31'b0, halt_req}, 32'h1);
        wr(2'd1, 32'h0, 1'b1);
        #1; chk("R9 halt cleared", {31'b0, halt_req}, 32'h0);

        // R3 / R4 advance table
        for (int i = 0; i < 9; i++) begin
            wr(2'd1, {19'b0, VEC[i][29:25], 8'h01}, 1'b1);
            wr(2'd0, {20'b0, VEC[i][24:13]}, 1'b1);
            pulse_pkt();
            rd(2'd0);
            chk((VEC[i][29:25] > 5'd8) ? "R4 clamped mask advance" : "R3 window advance",
                rv, {20'b0, VEC[i][12:1] | {11'b0, VEC[i][0]}});
        end

        // R3 sticky wrap (mask 31, pointer now 0 with wrap set)
        pulse_pkt();
        rd(2'd0); chk("R3 wrap stays set", rv, 32'h009);

        // R2 accept gating
        wr(2'd1, 32'h800, 1'b1);
        wr(2'd0, 32'h040, 1'b1);
        @(negedge clk); pkt_wr = 1; #1;
        chk("R2 disabled no write", {31'b0, trace_wr_en}, 32'h0);
        @(negedge clk); pkt_wr = 0;
        rd(2'd0); chk("R2 disabled no advance", rv, 32'h040);
        wr(2'd1, 32'h801, 1'b1);
        @(negedge clk); pkt_wr = 1; #1;
        chk("R2 write enable", {31'b0, trace_wr_en}, 32'h1);
        chk("R2 write address", {20'b0, trace_wr_addr}, 32'h040);
        @(negedge clk); pkt_wr = 0;
        rd(2'd0); chk("R2 advance by 8", rv, 32'h048);

        // R6 stop with a packet in flight
        wr(2'd1, 32'h805, 1'b1);
        wr(2'd0, 32'h100, 1'b1);
        @(negedge clk); trace_stop = 1; pkt_wr = 1;
        @(negedge clk); trace_stop = 0; pkt_wr = 0;
        rd(2'd0); chk("R6 packet kept on stop", rv, 32'h108);
        rd(2'd1); chk("R6 stop disables", rv & 32'h1, 32'h0);

        // R6 stop wins over start
        wr(2'd1, 32'h806, 1'b1);
        @(negedge clk); trace_start = 1; trace_stop = 1;
        @(negedge clk); trace_start = 0; trace_stop = 0;
        rd(2'd1); chk("R6 stop beats start", rv & 32'h1, 32'h0);

        // R5 start trigger
        @(negedge clk); trace_start = 1;
        @(negedge clk); trace_start = 0;
        rd(2'd1); chk("R5 start enables", rv & 32'h1, 32'h1);
        wr(2'd1, 32'h804, 1'b1);
        @(negedge clk); trace_start = 1;
        @(negedge clk); trace_start = 0;
        rd(2'd1); chk("R5 start ignored when not enabled", rv & 32'h1, 32'h0);

        // R10 watermark without stop
        wr(2'd2, 32'h010, 1'b1);
        wr(2'd1, 32'h800, 1'b1);
        wr(2'd0, 32'h000, 1'b1);
        wr(2'd1, 32'h801, 1'b1);
        pulse_pkt();
        pulse_pkt();
        @(negedge clk); @(negedge clk);
        rd(2'd1); chk("R10 watermark sets halt", rv, 32'h809);

        // R10 watermark with stop
        wr(2'd1, 32'h800, 1'b1);
        wr(2'd2, 32'h011, 1'b1);
        wr(2'd0, 32'h000, 1'b1);
        wr(2'd1, 32'h801, 1'b1);
        pulse_pkt();
        pulse_pkt();
        @(negedge clk); @(negedge clk);
        rd(2'd1); chk("R10 watermark stops trace", rv, 32'h808);
        rd(2'd0); chk("R10 pointer at watermark", rv, 32'h010);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule